// File: doc/BRIEF.md
# Status Readback Snapshot Packer

The block answers a status request that comes from a processing clock domain by sending a fixed-format snapshot of the current configuration to a downstream writer in an interface clock domain. The request is a single-cycle pulse. It passes through a two-stage synchronizer into the interface domain, and a rising-edge detector there turns it into exactly one capture strobe. On that strobe the configuration inputs are copied into five 32-bit status words. The words are then offered one at a time under a valid/ready handshake.

Configuration inputs are treated as quasi-static. They are sampled only on the capture cycle, so a change made while the words are being sent does not reach the snapshot. The stream-control field crosses into the interface domain through its own synchronizer, which resets to `6'b000001` (only the range stream enabled). Any request that reaches the interface domain while a snapshot is still being sent is dropped.

The request pulse must be wide enough for at least one interface clock edge to sample it high.

Top module: `statusSnapshotPacker`

## Requirements
- R1: After reset, `wordValid` is low and stays low until a status request has been captured.
- R2: One request pulse yields exactly five words. `wordValid` first rises after the second interface clock edge that follows the interface edge which first samples the request high.
- R3: Word 0 is `{8'hFF, mode[1:0], streamCtrl[5:0], threshold[15:0]}`. Bits [31:24] hold the tag, [23:22] the mode, [21:16] the stream control and [15:0] the threshold.
- R4: Word 1 is `{longChirpCycles[15:0], longListenCycles[15:0]}`, with the long chirp count in [31:16].
- R5: Word 2 is `{guardCycles[15:0], shortChirpCycles[15:0]}`, with the guard count in [31:16].
- R6: Word 3 is `{shortListenCycles[15:0], 10'b0, chirpsPerElev[5:0]}`. Word 4 is `{16'b0, idleGapCycles[15:0]}`. All pad bits are zero.
- R7: Words leave in the order 0, 1, 2, 3, 4. A word is accepted only in a cycle where `wordValid` and `wordReady` are both high. While `wordReady` is low, `wordValid` and `wordData` hold.
- R8: A request whose capture would fall while a snapshot is still being sent is ignored. This includes a capture in the very cycle that word 4 is accepted. Such a request produces no extra words.
- R9: Configuration inputs are sampled only on the capture cycle. Changing them during emission leaves the words of that snapshot unchanged.
- R10: After word 4 is accepted, `wordValid` is low for at least one cycle before the next snapshot begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifClk | input | 1 | Interface-domain clock |
| ifRstN | input | 1 | Asynchronous active-low reset, interface domain |
| statusReq | input | 1 | One-cycle status request from the processing domain |
| cfgMode | input | 2 | Radar mode |
| cfgStream | input | 6 | Stream control (synchronized internally) |
| cfgThreshold | input | 16 | Detection threshold |
| cfgLongChirp | input | 16 | Long chirp cycle count |
| cfgLongListen | input | 16 | Long listen cycle count |
| cfgGuard | input | 16 | Guard cycle count |
| cfgShortChirp | input | 16 | Short chirp cycle count |
| cfgShortListen | input | 16 | Short listen cycle count |
| cfgChirpsPerElev | input | 6 | Chirps per elevation step |
| cfgIdleGap | input | 16 | Idle gap cycle count |
| wordReady | input | 1 | Downstream writer accepts the current word |
| wordValid | output | 1 | A status word is presented |
| wordData | output | 32 | Current status word |

## Verification
Two things can happen in the same interface cycle: a new request can reach its capture edge exactly when word 4 is accepted. The bench provokes this by stalling `wordReady` on word 4. It then sends a request and raises `wordReady` so that the acceptance edge and the capture edge coincide. The cycle-accurate reference model counts the snapshot as still busy on that edge, so it expects the request to be dropped. The bench then confirms that only five words were delivered and that `wordValid` falls.

// File: rtl/statusPackPkg.sv
package statusPackPkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 5;
  localparam int FIELD_W    = 16;
  localparam int STREAM_W   = 6;
  localparam int MODE_W     = 2;
  localparam int CPE_W      = 6;
  localparam int TAG_W      = 8;
  localparam int IDX_W      = $clog2(NUM_WORDS);
  localparam int SYNC_DEPTH = 2;
  localparam logic [TAG_W-1:0]    STATUS_TAG   = 8'hFF;
  localparam logic [STREAM_W-1:0] STREAM_RESET = 6'b000001;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] idx;
  } snapCtrlT;
endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[s] <= RESET_VAL;
        else       stageQ[s] <= din;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[s] <= RESET_VAL;
        else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/snapCtrl.sv
module snapCtrl
  import statusPackPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqSync,
  input  logic     wordReady,
  output logic     wordValid,
  output snapCtrlT ctrl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic reqPrev;
  logic busy;
  logic [IDX_W-1:0] idx;
  logic reqRise;
  logic advance;

  assign reqRise = reqSync & ~reqPrev;
  assign advance = busy & wordReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= 1'b0;
      busy    <= 1'b0;
      idx     <= '0;
    end else begin
      reqPrev <= reqSync;
      if (reqRise && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (advance) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign wordValid    = busy;
  assign ctrl.capture = reqRise & ~busy;
  assign ctrl.idx     = idx;
endmodule

// File: rtl/snapData.sv
module snapData
  import statusPackPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  snapCtrlT            ctrl,
  input  logic [MODE_W-1:0]   cfgMode,
  input  logic [STREAM_W-1:0] streamSync,
  input  logic [FIELD_W-1:0]  cfgThreshold,
  input  logic [FIELD_W-1:0]  cfgLongChirp,
  input  logic [FIELD_W-1:0]  cfgLongListen,
  input  logic [FIELD_W-1:0]  cfgGuard,
  input  logic [FIELD_W-1:0]  cfgShortChirp,
  input  logic [FIELD_W-1:0]  cfgShortListen,
  input  logic [CPE_W-1:0]    cfgChirpsPerElev,
  input  logic [FIELD_W-1:0]  cfgIdleGap,
  output logic [WORD_W-1:0]   wordData
);
  localparam int PAD3_W = WORD_W - FIELD_W - CPE_W;
  localparam int PAD4_W = WORD_W - FIELD_W;

  logic [NUM_WORDS-1:0][WORD_W-1:0] snapQ;
  logic [NUM_WORDS-1:0][WORD_W-1:0] snapD;

  always_comb begin
    snapD[0] = {STATUS_TAG, cfgMode, streamSync, cfgThreshold};
    snapD[1] = {cfgLongChirp, cfgLongListen};
    snapD[2] = {cfgGuard, cfgShortChirp};
    snapD[3] = {cfgShortListen, {PAD3_W{1'b0}}, cfgChirpsPerElev};
    snapD[4] = {{PAD4_W{1'b0}}, cfgIdleGap};
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)             snapQ[w] <= '0;
      else if (ctrl.capture) snapQ[w] <= snapD[w];
  end

  always_comb begin
    wordData = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (ctrl.idx == IDX_W'(w)) wordData = snapQ[w];
  end
endmodule

// File: rtl/statusSnapshotPacker.sv
module statusSnapshotPacker
  import statusPackPkg::*;
(
  input  logic                ifClk,
  input  logic                ifRstN,
  input  logic                statusReq,
  input  logic [MODE_W-1:0]   cfgMode,
  input  logic [STREAM_W-1:0] cfgStream,
  input  logic [FIELD_W-1:0]  cfgThreshold,
  input  logic [FIELD_W-1:0]  cfgLongChirp,
  input  logic [FIELD_W-1:0]  cfgLongListen,
  input  logic [FIELD_W-1:0]  cfgGuard,
  input  logic [FIELD_W-1:0]  cfgShortChirp,
  input  logic [FIELD_W-1:0]  cfgShortListen,
  input  logic [CPE_W-1:0]    cfgChirpsPerElev,
  input  logic [FIELD_W-1:0]  cfgIdleGap,
  input  logic                wordReady,
  output logic                wordValid,
  output logic [WORD_W-1:0]   wordData
);
  logic                reqSync;
  logic [STREAM_W-1:0] streamSync;
  snapCtrlT            ctrl;

  syncChain #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RESET_VAL(1'b0)) i_reqSync (
    .clk(ifClk), .rstN(ifRstN), .din(statusReq), .dout(reqSync)
  );

  syncChain #(.WIDTH(STREAM_W), .STAGES(SYNC_DEPTH), .RESET_VAL(STREAM_RESET)) i_streamSync (
    .clk(ifClk), .rstN(ifRstN), .din(cfgStream), .dout(streamSync)
  );

  snapCtrl i_ctrl (
    .clk(ifClk), .rstN(ifRstN), .reqSync(reqSync), .wordReady(wordReady),
    .wordValid(wordValid), .ctrl(ctrl)
  );

  snapData i_data (
    .clk(ifClk), .rstN(ifRstN), .ctrl(ctrl),
    .cfgMode(cfgMode), .streamSync(streamSync), .cfgThreshold(cfgThreshold),
    .cfgLongChirp(cfgLongChirp), .cfgLongListen(cfgLongListen),
    .cfgGuard(cfgGuard), .cfgShortChirp(cfgShortChirp),
    .cfgShortListen(cfgShortListen), .cfgChirpsPerElev(cfgChirpsPerElev),
    .cfgIdleGap(cfgIdleGap), .wordData(wordData)
  );
endmodule

// File: rtl/statusSnapshotPackerChecker.sv
module statusSnapshotPackerChecker
  import statusPackPkg::*;
(
  input logic              ifClk,
  input logic              ifRstN,
  input logic              wordValid,
  input logic              wordReady,
  input logic [WORD_W-1:0] wordData
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(NUM_WORDS - 1);

  // beat position as seen from the ports alone
  logic [IDX_W-1:0] beat;
  always_ff @(posedge ifClk or negedge ifRstN)
    if (!ifRstN) beat <= '0;
    else if (wordValid && wordReady) beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;

  assert_hold_R7: assert property (@(posedge ifClk) disable iff (!ifRstN)
    wordValid && !wordReady |=> wordValid && $stable(wordData));

  assert_tag_first_R3: assert property (@(posedge ifClk) disable iff (!ifRstN)
    wordValid && beat == '0 |-> wordData[31:24] == STATUS_TAG);

  assert_pad_word3_R6: assert property (@(posedge ifClk) disable iff (!ifRstN)
    wordValid && beat == IDX_W'(3) |-> wordData[15:6] == '0);

  assert_pad_word4_R6: assert property (@(posedge ifClk) disable iff (!ifRstN)
    wordValid && beat == LAST_BEAT |-> wordData[31:16] == '0);

  assert_gap_R10: assert property (@(posedge ifClk) disable iff (!ifRstN)
    wordValid && wordReady && beat == LAST_BEAT |=> !wordValid);

  assert_whole_snapshot_R2: assert property (@(posedge ifClk) disable iff (!ifRstN)
    $fell(wordValid) |-> beat == '0);
endmodule

bind statusSnapshotPacker statusSnapshotPackerChecker i_checker (
  .ifClk(ifClk), .ifRstN(ifRstN), .wordValid(wordValid),
  .wordReady(wordReady), .wordData(wordData)
);

// File: tb/test_statusSnapshotPacker.sv
`timescale 1ns/1ps
module test_statusSnapshotPacker;
  logic ifClk = 1'b0;
  logic procClk = 1'b0;
  logic ifRstN = 1'b0;
  logic statusReq = 1'b0;
  logic [1:0]  md = '0;
  logic [5:0]  st = '0;
  logic [15:0] thr = '0, lc = '0, ll = '0, gd = '0, sc = '0, sl = '0, ig = '0;
  logic [5:0]  cpe = '0;
  logic wordReady = 1'b0;
  logic wordValid;
  logic [31:0] wordData;

  // interface clock edges at 5,15,...; processing clock edges at 8,18,...
  initial begin #5; forever begin ifClk = 1'b1; #5; ifClk = 1'b0; #5; end end
  initial begin #8; forever begin procClk = 1'b1; #5; procClk = 1'b0; #5; end end

  statusSnapshotPacker i_statusSnapshotPacker (
    .ifClk(ifClk), .ifRstN(ifRstN), .statusReq(statusReq),
    .cfgMode(md), .cfgStream(st), .cfgThreshold(thr),
    .cfgLongChirp(lc), .cfgLongListen(ll), .cfgGuard(gd),
    .cfgShortChirp(sc), .cfgShortListen(sl), .cfgChirpsPerElev(cpe),
    .cfgIdleGap(ig), .wordReady(wordReady),
    .wordValid(wordValid), .wordData(wordData)
  );

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] expQ[$];
  int capQ[$];
  int edgeN = 0;
  logic prevReq = 1'b0;

  function automatic logic [31:0] mkWord(input int w);
    case (w)
      0: return {8'hFF, md, st, thr};
      1: return {lc, ll};
      2: return {gd, sc};
      3: return {sl, 10'b0, cpe};
      default: return {16'b0, ig};
    endcase
  endfunction

  always @(posedge ifClk or negedge ifRstN) begin
    if (!ifRstN) begin
      expQ.delete(); capQ.delete(); prevReq = 1'b0; edgeN = 0;
    end else begin
      automatic bit wasBusy = expQ.size() > 0;
      automatic bit capNow;
      edgeN++;
      if (wasBusy && wordReady) void'(expQ.pop_front());
      capNow = capQ.size() > 0 && capQ[0] == edgeN;
      if (capNow) void'(capQ.pop_front());
      if (capNow && !wasBusy)
        for (int w = 0; w < 5; w++) expQ.push_back(mkWord(w));
      if (statusReq && !prevReq) capQ.push_back(edgeN + 2);
      prevReq = statusReq;
    end
  end

  // ---------------- per-cycle compare and ready driver ----------------
  int readyMode = 0;   // 0 high, 1 alternate, 2 low, 3 stall on word 4
  int gotCount = 0;
  logic [31:0] gotW[$];
  bit lastWasFinal = 1'b0;
  int negN = 0;

  always @(negedge ifClk) begin
    if (ifRstN) begin
      negN++;
      check({phase, " valid"}, {31'b0, wordValid}, {31'b0, expQ.size() > 0});
      if (wordValid && expQ.size() > 0) check({phase, " data"}, wordData, expQ[0]);
      if (lastWasFinal) check("R10 gap after word 4", {31'b0, wordValid}, 32'd0);
      case (readyMode)
        0: wordReady = 1'b1;
        1: wordReady = negN[0];
        2: wordReady = 1'b0;
        default: wordReady = (gotCount % 5) != 4;
      endcase
      lastWasFinal = 1'b0;
      if (wordValid && wordReady) begin
        gotW.push_back(wordData);
        gotCount++;
        if (gotCount % 5 == 0) lastWasFinal = 1'b1;
      end
    end else begin
      wordReady = 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge ifClk);
  endtask

  task automatic sendReq();
    @(posedge procClk); #1 statusReq = 1'b1;
    @(posedge procClk); #1 statusReq = 1'b0;
  endtask

  task automatic setCfg(input int seed);
    md = 2'(seed); st = 6'(seed * 7 + 3); thr = 16'(seed * 16'h1357 + 16'h0A0B);
    lc = 16'(16'hC000 + seed); ll = 16'(16'h3000 + seed * 3);
    gd = 16'(16'h0055 + seed); sc = 16'(16'hAA00 + seed * 5);
    sl = 16'(16'h7E00 + seed); cpe = 6'(seed * 11 + 1); ig = 16'(16'h8001 + seed * 9);
  endtask

  // checks the five words taken from gotW against a configuration seed
  task automatic checkSnap(input int seed, input int firstIdx);
    automatic logic [1:0] m; automatic logic [5:0] s, c;
    automatic logic [15:0] t, a, b, g, h, l, i;
    md = md; // keep current inputs untouched
    m = 2'(seed); s = 6'(seed * 7 + 3); t = 16'(seed * 16'h1357 + 16'h0A0B);
    a = 16'(16'hC000 + seed); b = 16'(16'h3000 + seed * 3);
    g = 16'(16'h0055 + seed); h = 16'(16'hAA00 + seed * 5);
    l = 16'(16'h7E00 + seed); c = 6'(seed * 11 + 1); i = 16'(16'h8001 + seed * 9);
    if (gotW.size() < firstIdx + 5) begin
      check("R2 word count", gotW.size(), firstIdx + 5);
      return;
    end
    check("R3 tag", {24'b0, gotW[firstIdx][31:24]}, 32'hFF);
    check("R3 mode", {30'b0, gotW[firstIdx][23:22]}, {30'b0, m});
    check("R3 stream", {26'b0, gotW[firstIdx][21:16]}, {26'b0, s});
    check("R3 threshold", {16'b0, gotW[firstIdx][15:0]}, {16'b0, t});
    check("R4 word1", gotW[firstIdx + 1], {a, b});
    check("R5 word2", gotW[firstIdx + 2], {g, h});
    check("R6 word3", gotW[firstIdx + 3], {l, 10'b0, c});
    check("R6 word4", gotW[firstIdx + 4], {16'b0, i});
  endtask

  initial begin
    int base;
    #32 ifRstN = 1'b1;
    phase = "R1";
    cyc(6);
    check("R1 idle after reset", {31'b0, wordValid}, 32'd0);

    // R2..R6: basic snapshot with ready always high
    phase = "R2";
    setCfg(1); readyMode = 0; cyc(4);
    base = gotW.size();
    sendReq();
    cyc(12);
    check("R2 five words", gotW.size(), base + 5);
    checkSnap(1, base);

    // R7: stalling ready pattern
    phase = "R7";
    setCfg(2); readyMode = 1; cyc(4);
    base = gotW.size();
    sendReq(); readyMode = 2; cyc(5);
    check("R7 no accept while ready low", gotW.size(), base);
    readyMode = 1; cyc(20);
    check("R7 order kept", gotW.size(), base + 5);
    checkSnap(2, base);

    // R8: request during emission, and one landing on the word-4 acceptance edge
    phase = "R8";
    setCfg(3); readyMode = 3; cyc(4);
    base = gotW.size();
    sendReq(); cyc(2);
    sendReq();               // arrives mid-emission
    cyc(10);
    check("R8 stalled at word 4", gotW.size(), base + 4);
    sendReq();
    @(posedge ifClk);
    readyMode = 0;           // acceptance of word 4 coincides with capture edge
    cyc(12);
    check("R8 extra requests ignored", gotW.size(), base + 5);
    checkSnap(3, base);

    // R9: configuration changed during emission
    phase = "R9";
    setCfg(4); readyMode = 1; cyc(4);
    base = gotW.size();
    sendReq(); cyc(4);
    setCfg(9);
    cyc(16);
    checkSnap(4, base);

    // R10: back-to-back snapshots
    phase = "R10";
    setCfg(5); readyMode = 0; cyc(4);
    base = gotW.size();
    sendReq(); cyc(6);
    sendReq(); cyc(12);
    check("R10 two snapshots", gotW.size(), base + 10);
    checkSnap(5, base);
    checkSnap(5, base + 5);

    cyc(3);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule